// File: doc/BRIEF.md
# SIMD Saturating Rounding Shifter

This block treats two 128-bit vectors as packed lanes of 8, 16, 32 or 64 bits. Each lane of the data vector is shifted by a signed count taken from the matching lane of the control vector. A count of zero or more shifts the lane left. A negative count shifts it right with round-to-nearest, where halves round upward. The shifted value is then clamped to the lane's range, read as signed or as unsigned.

A width select either processes the whole vector or only its lower 64 bits. A per-operation flag reports whether any active lane clamped. A sticky flag accumulates saturation events until software-side control clears it.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream, with one register stage between them. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle (`in_ready = !out_valid || out_ready`). A result that is held back by a low `out_ready` keeps `out_valid`, `out_data` and `out_sat` unchanged until it is taken. The producer may hold `in_valid` and the operands for as long as it likes. The sticky flag and its clear input are plain control pins.

Top module: `simd_qrshl`

## Requirements
- R1: `in_size` selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W+W-1 : i*W] of the data, control and result vectors.
- R2: A lane's shift count is bits [7:0] of its control lane, read as an 8-bit two's-complement number. All higher bits of the control lane have no effect on the result.
- R3: For a count from 0 to 127, the lane is shifted left by that count with no bits lost. Any value outside the lane range is clamped, and this includes a nonzero element shifted by the lane width or more.
- R4: For a count from -1 to -128 with magnitude m, the result is floor((x + 2^(m-1)) / 2^m). When m exceeds the lane width the result is 0. A right shift never saturates.
- R5: With `in_uns`=0, lanes are read as signed and clamped to [-2^(W-1), 2^(W-1)-1]. With `in_uns`=1, lanes are read as unsigned and clamped to [0, 2^W-1]. The count stays signed in both modes.
- R6: With `in_full`=0, result bits [127:64] are 0 and upper-half lanes never raise saturation. With `in_full`=1, all lanes are processed alike.
- R7: `out_sat` is high with a result exactly when at least one active lane of that operation was clamped.
- R8: `sat_sticky` goes high at the edge that accepts an operation that saturates, and stays high until an edge with `sat_clear` high and no saturating acceptance. If both happen on the same edge, the set wins.
- R9: A result appears on `out_valid`/`out_data` one clock after acceptance. `in_ready` = !out_valid || out_ready. While `out_valid` is high and `out_ready` is low, the output holds stable.
- R10: After reset, `out_valid`, `out_sat` and `sat_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Block can take an operand set |
| in_data | input | 128 | Packed data lanes |
| in_ctl | input | 128 | Packed control lanes, low byte of each holds the signed count |
| in_size | input | 2 | Lane width code (8 << code bits) |
| in_uns | input | 1 | 1: data lanes are unsigned |
| in_full | input | 1 | 1: process all 128 bits, 0: lower 64 only |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Packed result lanes |
| out_sat | output | 1 | Some active lane of this result clamped |
| sat_clear | input | 1 | Clears the sticky flag |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
On every cycle, the assertions check the stream hold rule and the zeroed upper half in 64-bit mode. They also check the sticky flag: it sets on a saturating acceptance, it holds without a clear, and it rises only together with a saturated result. The lane arithmetic can only be shown through the bench's scenarios. This covers rounding at each magnitude, clamp values in both signedness modes, counts at and beyond the lane width, -128, and ignored upper control bits. In those scenarios each result is compared with an exact wide-integer model, under random back-pressure.

// File: rtl/simd_qrshl_pkg.sv
package simd_qrshl_pkg;
  localparam int CNT_W = 8;
  localparam int NUM_SZ = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } lane_sz_e;
endpackage

// File: rtl/simd_qrshl_lane.sv
module simd_qrshl_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] elem,
  input  logic [7:0]   cnt,
  input  logic         is_uns,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam int XW = 2 * W + 2;
  localparam logic [8:0] W9 = 9'(W);

  logic signed [XW-1:0] x, one, sh, rnd, lim_hi, lim_lo;
  logic       sx;
  logic [6:0] lmag;
  logic [8:0] rmag;
  logic       ovf;
  logic       rnd_unused;

  assign sx   = ~is_uns & elem[W-1];
  assign lmag = cnt[6:0];
  assign rmag = 9'd256 - {1'b0, cnt};

  always_comb begin
    one    = '0;
    one[0] = 1'b1;
    x      = {{(XW-W){sx}}, elem};
    lim_hi = is_uns ? ((one <<< W) - one) : ((one <<< (W-1)) - one);
    lim_lo = is_uns ? '0 : -(one <<< (W-1));
    sh     = x <<< lmag;
    rnd    = (x + (one <<< (rmag - 9'd1))) >>> rmag;
    ovf    = 1'b0;
    res    = '0;
    if (!cnt[7]) begin
      if ({2'b0, lmag} >= W9) ovf = (elem != '0);
      else                    ovf = (sh > lim_hi) || (sh < lim_lo);
      if (ovf) res = x[XW-1] ? lim_lo[W-1:0] : lim_hi[W-1:0];
      else     res = sh[W-1:0];
    end else if (rmag <= W9) begin
      res = rnd[W-1:0];
    end
    sat = ovf;
  end

  assign rnd_unused = ^rnd[XW-1:W];
endmodule

// File: rtl/simd_qrshl_bank.sv
module simd_qrshl_bank #(
  parameter int VEC_W = 128,
  parameter int W     = 8
) (
  input  logic [VEC_W-1:0] data,
  input  logic [VEC_W-1:0] ctl,
  input  logic             is_uns,
  input  logic             full,
  output logic [VEC_W-1:0] res,
  output logic             sat
);
  localparam int HALF_W = VEC_W / 2;
  localparam int LANES  = VEC_W / W;

  logic [LANES-1:0] lane_sat;
  logic             ctl_unused;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit UPPER = (i * W >= HALF_W);
    logic [W-1:0] lr;
    logic         ls;
    logic         live;

    simd_qrshl_lane #(.W(W)) u_lane (
      .elem   (data[i*W +: W]),
      .cnt    (ctl[i*W +: 8]),
      .is_uns (is_uns),
      .res    (lr),
      .sat    (ls)
    );

    assign live             = !UPPER || full;
    assign res[i*W +: W]    = live ? lr : '0;
    assign lane_sat[i]      = live & ls;
  end

  assign sat        = |lane_sat;
  assign ctl_unused = ^ctl;
endmodule

// File: rtl/simd_qrshl.sv
module simd_qrshl
  import simd_qrshl_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_ctl,
  input  logic [1:0]       in_size,
  input  logic             in_uns,
  input  logic             in_full,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_sat,
  input  logic             sat_clear,
  output logic             sat_sticky
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0]  bank_res [NUM_SZ];
  logic [NUM_SZ-1:0] bank_sat;
  logic [VEC_W-1:0]  nxt_res;
  logic              nxt_sat;
  logic              accept;
  logic              held_full;
  lane_sz_e          sz;

  for (genvar k = 0; k < NUM_SZ; k++) begin : g_bank
    simd_qrshl_bank #(.VEC_W(VEC_W), .W(8 << k)) u_bank (
      .data   (in_data),
      .ctl    (in_ctl),
      .is_uns (in_uns),
      .full   (in_full),
      .res    (bank_res[k]),
      .sat    (bank_sat[k])
    );
  end

  assign sz = lane_sz_e'(in_size);

  always_comb begin
    case (sz)
      SZ_8:    begin nxt_res = bank_res[0]; nxt_sat = bank_sat[0]; end
      SZ_16:   begin nxt_res = bank_res[1]; nxt_sat = bank_sat[1]; end
      SZ_32:   begin nxt_res = bank_res[2]; nxt_sat = bank_sat[2]; end
      default: begin nxt_res = bank_res[3]; nxt_sat = bank_sat[3]; end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= 1'b0;
      held_full <= 1'b1;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= nxt_res;
        out_sat   <= nxt_sat;
        held_full <= in_full;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_sticky <= 1'b0;
    else        sat_sticky <= (sat_sticky && !sat_clear) || (accept && nxt_sat);
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sat));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !held_full |-> out_data[VEC_W-1:HALF_W] == '0);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && nxt_sat |=> sat_sticky);

  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clear |=> sat_sticky);

  // R7
  sticky_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_sticky) |-> out_valid && out_sat);
endmodule

// File: tb/simd_qrshl_test.sv
`timescale 1ns/1ps
module simd_qrshl_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [127:0] in_ctl = '0;
  logic [1:0]   in_size = '0;
  logic         in_uns = 1'b0;
  logic         in_full = 1'b1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_sat;
  logic         sat_clear = 1'b0;
  logic         sat_sticky;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  bp_en = 1'b0;

  typedef struct {
    logic [127:0] d;
    logic         s;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  simd_qrshl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctl(in_ctl), .in_size(in_size), .in_uns(in_uns),
    .in_full(in_full), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat), .sat_clear(sat_clear),
    .sat_sticky(sat_sticky)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Wide-integer model of the requirements (R1-style lane layout, R2..R6)
  function automatic void ref_op(input logic [127:0] d, input logic [127:0] c,
                                 input logic [1:0] sz, input logic uns, input logic full,
                                 output logic [127:0] r, output logic s);
    int w;
    int n;
    w = 8 << sz;
    n = 128 / w;
    r = '0;
    s = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] e;
      logic [7:0]  cc;
      logic signed [199:0] v, one, hi, lo;
      int cnt;
      if (!full && i * w >= 64) continue;
      e = '0;
      for (int b = 0; b < w; b++) e[b] = d[i*w+b];
      for (int b = 0; b < 8; b++) cc[b] = c[i*w+b];
      one = 1;
      v = {136'b0, e};
      if (!uns && e[w-1]) v = v - (one <<< w);
      cnt = int'($signed(cc));
      if (cnt >= 0) v = v <<< cnt;
      else          v = (v + (one <<< (-cnt - 1))) >>> (-cnt);
      hi = uns ? ((one <<< w) - one) : ((one <<< (w - 1)) - one);
      lo = uns ? 200'sd0 : -(one <<< (w - 1));
      if (v > hi)      begin v = hi; s = 1'b1; end
      else if (v < lo) begin v = lo; s = 1'b1; end
      for (int b = 0; b < w; b++) r[i*w+b] = v[b];
    end
  endfunction

  task automatic drive(input logic [127:0] d, input logic [127:0] c, input logic [1:0] sz,
                       input logic uns, input logic full,
                       input logic [127:0] ed, input logic es, input string tag);
    exp_t it;
    @(negedge clk);
    in_data = d; in_ctl = c; in_size = sz; in_uns = uns; in_full = full; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.d = ed; it.s = es; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send(input logic [127:0] d, input logic [127:0] c, input logic [1:0] sz,
                      input logic uns, input logic full, input string tag);
    logic [127:0] r;
    logic s;
    ref_op(d, c, sz, uns, full, r, s);
    drive(d, c, sz, uns, full, r, s, tag);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    #5;
  endtask

  always @(negedge clk) out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;

  // Monitor: pops expected results, also checks stall hold (R9)
  initial begin
    bit prev_stall;
    logic [127:0] prev_d;
    logic prev_s;
    prev_stall = 1'b0;
    prev_d = '0;
    prev_s = 1'b0;
    forever begin
      @(negedge clk);
      #5;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && out_data == prev_d && out_sat == prev_s, "R9 hold", out_data, prev_d);
        prev_stall = out_valid && !out_ready;
        prev_d = out_data;
        prev_s = out_sat;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected result", out_data, '0);
          end else begin
            exp_t it;
            it = q.pop_front();
            check(out_data == it.d, {it.tag, " data (R1 R3 R4 R5)"}, out_data, it.d);
            check(out_sat == it.s, {it.tag, " R7 out_sat"}, {127'b0, out_sat}, {127'b0, it.s});
          end
        end
      end
    end
  end

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic rand_op(input string tag);
    logic [1:0] sz;
    logic [127:0] d, c;
    int w;
    sz = 2'($urandom % 4);
    w = 8 << sz;
    d = rand128();
    c = rand128();
    for (int i = 0; i < 128 / w; i++) begin
      int k;
      logic [7:0] cnt;
      k = $urandom % 5;
      case (k)
        0: cnt = 8'($urandom);
        1: cnt = 8'($urandom % (w + 2));
        2: cnt = 8'(-(1 + int'($urandom % (w + 2))));
        3: cnt = ($urandom % 2) ? 8'h80 : 8'h7F;
        default: cnt = 8'($urandom % 3);
      endcase
      for (int b = 0; b < 8; b++) c[i*w+b] = cnt[b];
      if ($urandom % 3 == 0)
        for (int b = 1; b < w; b++) d[i*w+b] = d[i*w];
    end
    send(d, c, sz, 1'($urandom), 1'($urandom), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R10 reset state
    check(!out_valid && !out_sat && !sat_sticky, "R10 reset",
          {125'b0, out_valid, out_sat, sat_sticky}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 signed bytes: rounding right and clamping left
    drive({88'b0, 8'h06, 8'h80, 8'h7F, 8'hFB, 8'h05},
          {88'b0, 8'hFE, 8'h01, 8'h01, 8'hFF, 8'hFF}, 2'd0, 1'b0, 1'b1,
          128'h00000000_00000000_00000002_807FFE03, 1'b1, "R4 R5 signed bytes");
    drain();
    check(sat_sticky, "R8 set after saturating op", {127'b0, sat_sticky}, 128'd1);

    // R2 upper control bits ignored, 16-bit lanes
    drive({96'b0, 16'h0006, 16'h0010}, {96'b0, 16'h55FE, 16'hAB02}, 2'd1, 1'b0, 1'b1,
          128'h00000000_00000000_00000000_00020040, 1'b0, "R2 upper ctl bits");
    drain();
    check(sat_sticky, "R8 held over clean op", {127'b0, sat_sticky}, 128'd1);

    @(negedge clk) sat_clear = 1'b1;
    @(negedge clk) sat_clear = 1'b0;
    #5;
    check(!sat_sticky, "R8 cleared", {127'b0, sat_sticky}, '0);

    // R5 R4 unsigned bytes, magnitude beyond width gives 0
    sat_clear = 1'b1;
    drive({96'b0, 8'h03, 8'h01, 8'h80, 8'hFF}, {96'b0, 8'hF7, 8'h07, 8'h01, 8'hFF},
          2'd0, 1'b1, 1'b1, 128'h00000000_00000000_00000000_0080FF80, 1'b1, "R5 R4 unsigned bytes");
    sat_clear = 1'b0;
    drain();
    check(sat_sticky, "R8 set beats clear", {127'b0, sat_sticky}, 128'd1);
    @(negedge clk) sat_clear = 1'b1;
    @(negedge clk) sat_clear = 1'b0;

    // R6 lower half only: saturating upper lane is masked
    drive({64'h7FFF_FFFF_FFFF_FFFF, 64'd1}, {64'd1, 64'd3}, 2'd3, 1'b0, 1'b0,
          128'h8, 1'b0, "R6 half mode");
    drain();
    check(!sat_sticky, "R6 upper lane no sticky", {127'b0, sat_sticky}, '0);

    // R3 left shift by lane width or more, 32-bit lanes
    drive({32'h40000000, 32'hFFFFFFFF, 32'h0, 32'h1}, {32'h0, 32'd40, 32'd100, 32'd32},
          2'd2, 1'b0, 1'b1, {32'h40000000, 32'h80000000, 32'h0, 32'h7FFFFFFF}, 1'b1,
          "R3 count >= width");

    // R4 count -128 and magnitude equal to lane width, 64-bit lanes
    drive({64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, {64'h00C0, 64'h0080},
          2'd3, 1'b0, 1'b1, '0, 1'b0, "R4 magnitude 64 and 128");
    drain();

    // R1 all lane sizes, random, no back-pressure
    for (int n = 0; n < 200; n++) rand_op("R1 random");
    drain();

    // R9 random with back-pressure
    bp_en = 1'b1;
    for (int n = 0; n < 300; n++) rand_op("R9 random backpressure");
    drain();
    bp_en = 1'b0;
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule